// File: doc/BRIEF.md
# Call, Return and Interrupt Stack Sequencer

This block handles all stack traffic and vector loads for control transfers in an 8-bit processor core. It covers subroutine call and return, software break, return from interrupt, pushing and pulling the accumulator or the status byte, servicing a pending non-maskable or maskable interrupt, and the reset entry. The core supplies its current program counter, stack pointer, status byte, accumulator and call target, along with an operation code and a one-cycle start strobe. The sequencer then makes one byte access per cycle on a single-port memory whose read data is combinational. When it finishes, it returns the new register values and the number of processor cycles the operation is charged with.

The stack is fixed to page 0x01, so every stack byte lives at 0x0100 plus the 8-bit pointer. The pointer wraps within that page. Each vector is stored low byte first at the top of the address space. Instruction fetch and arithmetic are not part of this block.

Top module: `stk_seq`

## Requirements
- R1: Stack accesses use address {0x01, SP}. A push writes at the current SP and then decrements it, and a pull increments SP and then reads. SP wraps modulo 256, so a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R2: Call (opKind 0) writes the high byte of PC-1 and then its low byte. PC becomes targetIn and SP drops by 2.
- R3: Return (opKind 1) reads the low byte and then the high byte. PC becomes that word plus 1 and SP rises by 2.
- R4: Break (opKind 2) writes PC high, then PC low, then statusIn OR 0x10. It then reads the vector at 0xFFFE/0xFFFF. SP drops by 3 and the final status is statusIn OR 0x14.
- R5: Interrupt service (opKind 8), when an interrupt is taken, writes PC high, PC low and then statusIn unchanged. It then loads PC from 0xFFFA (non-maskable) or 0xFFFE (maskable). SP drops by 3 and status bit 2 (interrupt-disable) is set.
- R6: With both lines pending, the non-maskable interrupt wins. A maskable request with statusIn bit 2 set, or no request at all, completes with no memory access, all outputs equal to the inputs, and a cycle count of 0.
- R7: Return from interrupt (opKind 3) reads status, then PC low, then PC high, from SP+1 to SP+3. PC is loaded with no +1 and SP rises by 3.
- R8: Push accumulator (4) and push status (6) write one byte. Pull accumulator (5) loads A, sets status bit 1 to (A==0) and bit 7 to A bit 7, and keeps the other bits. Pull status (7) loads the status byte.
- R9: Reset entry (opKind 9) reads PC from 0xFFFC/0xFFFD, performs no write, decrements SP by 3 and sets status bit 2.
- R10: After power-up reset, pcOut=0x0000, spOut=0xFD, statusOut=0x34, accOut=0x00, and busy is low.
- R11: cyclesOut reports call 6, return 6, break 7, return-from-interrupt 6, push 3, pull 4, interrupt 7, reset 7, and 0 for nothing taken.
- R12: busy is high from the cycle after an accepted start until the last access, which happens one access per cycle. done pulses for exactly one cycle together with the updated outputs. A start while busy is ignored, and memEn stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe, taken only while idle |
| opKind | input | 4 | Operation code (see requirements) |
| pcIn | input | 16 | Current program counter |
| spIn | input | 8 | Current stack pointer |
| statusIn | input | 8 | Current status byte |
| accIn | input | 8 | Current accumulator |
| targetIn | input | 16 | Call target address |
| nmiPend | input | 1 | Non-maskable interrupt pending |
| irqPend | input | 1 | Maskable interrupt pending |
| memRdata | input | 8 | Combinational read data for memAddr |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Write data |
| pcOut | output | 16 | Resulting program counter |
| spOut | output | 8 | Resulting stack pointer |
| statusOut | output | 8 | Resulting status byte |
| accOut | output | 8 | Resulting accumulator |
| cyclesOut | output | 4 | Charged processor cycles |

## Verification
The assertions assume that memRdata answers in the same cycle as the address, and that pcIn, spIn, statusIn, accIn, targetIn and the interrupt lines are valid in the start cycle. The bench uses a combinational byte store that holds the stack page and the vector bytes. It drives start for exactly one cycle, only while idle, except for one deliberate start raised mid-sequence. Only the stack page and the vectors are ever addressed, so any stray address shows up as a mismatch against the expected access list.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  // external operation codes
  localparam logic [3:0] OPC_CALL  = 4'd0;
  localparam logic [3:0] OPC_RET   = 4'd1;
  localparam logic [3:0] OPC_BRK   = 4'd2;
  localparam logic [3:0] OPC_RTI   = 4'd3;
  localparam logic [3:0] OPC_PSHA  = 4'd4;
  localparam logic [3:0] OPC_PLLA  = 4'd5;
  localparam logic [3:0] OPC_PSHP  = 4'd6;
  localparam logic [3:0] OPC_PLLP  = 4'd7;
  localparam logic [3:0] OPC_INT   = 4'd8;
  localparam logic [3:0] OPC_RST   = 4'd9;

  typedef enum logic [3:0] {
    S_CALL, S_RET, S_BRK, S_RTI, S_PSHA, S_PLLA,
    S_PSHP, S_PLLP, S_NMI, S_IRQ, S_RST, S_NONE
  } seqOp_e;

  typedef enum logic [2:0] {
    W_PCHI, W_PCLO, W_RETHI, W_RETLO, W_ST, W_STBRK, W_ACC
  } wsrc_e;

  typedef struct packed {
    logic       load;    // latch inputs, start sequence
    logic       access;  // memory access this cycle
    logic       write;   // access is a write
    logic       useVec;  // address from vector instead of stack
    logic       vecHi;   // vector high byte
    logic [2:0] spOff;   // two's complement stack offset
    wsrc_e      wsrc;    // write data source
    logic       capLo;   // capture read byte as low half
    logic       capSt;   // capture read byte as status
    logic       finish;  // last cycle of the sequence
  } ctrl_t;

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [3:0] opKind,
  input  logic       nmiPend,
  input  logic       irqPend,
  input  logic       iMask,
  output ctrl_t      ctrl,
  output seqOp_e     opCur,
  output logic       busy
);

  logic              busyR;
  seqOp_e            opR;
  logic [STEP_W-1:0] stepR;

  function automatic seqOp_e decodeOp(input logic [3:0] k, input logic nmi,
                                      input logic irq, input logic msk);
    case (k)
      OPC_CALL: return S_CALL;
      OPC_RET:  return S_RET;
      OPC_BRK:  return S_BRK;
      OPC_RTI:  return S_RTI;
      OPC_PSHA: return S_PSHA;
      OPC_PLLA: return S_PLLA;
      OPC_PSHP: return S_PSHP;
      OPC_PLLP: return S_PLLP;
      OPC_INT:  return nmi ? S_NMI : ((irq && !msk) ? S_IRQ : S_NONE);
      OPC_RST:  return S_RST;
      default:  return S_NONE;
    endcase
  endfunction

  always_comb begin
    ctrl       = '0;
    ctrl.wsrc  = W_PCHI;
    ctrl.load  = startValid && !busyR;
    if (busyR) begin
      case (opR)
        S_CALL: begin
          ctrl.access = 1'b1; ctrl.write = 1'b1;
          if (stepR == 0) begin ctrl.wsrc = W_RETHI; ctrl.spOff = 3'd0; end
          else begin ctrl.wsrc = W_RETLO; ctrl.spOff = 3'b111; ctrl.finish = 1'b1; end
        end
        S_RET: begin
          ctrl.access = 1'b1;
          if (stepR == 0) begin ctrl.spOff = 3'd1; ctrl.capLo = 1'b1; end
          else begin ctrl.spOff = 3'd2; ctrl.finish = 1'b1; end
        end
        S_BRK, S_NMI, S_IRQ: begin
          ctrl.access = 1'b1;
          case (stepR)
            3'd0: begin ctrl.write = 1'b1; ctrl.wsrc = W_PCHI; ctrl.spOff = 3'd0; end
            3'd1: begin ctrl.write = 1'b1; ctrl.wsrc = W_PCLO; ctrl.spOff = 3'b111; end
            3'd2: begin
              ctrl.write = 1'b1; ctrl.spOff = 3'b110;
              ctrl.wsrc  = (opR == S_BRK) ? W_STBRK : W_ST;
            end
            3'd3: begin ctrl.useVec = 1'b1; ctrl.capLo = 1'b1; end
            default: begin ctrl.useVec = 1'b1; ctrl.vecHi = 1'b1; ctrl.finish = 1'b1; end
          endcase
        end
        S_RTI: begin
          ctrl.access = 1'b1;
          case (stepR)
            3'd0:    begin ctrl.spOff = 3'd1; ctrl.capSt = 1'b1; end
            3'd1:    begin ctrl.spOff = 3'd2; ctrl.capLo = 1'b1; end
            default: begin ctrl.spOff = 3'd3; ctrl.finish = 1'b1; end
          endcase
        end
        S_PSHA, S_PSHP: begin
          ctrl.access = 1'b1; ctrl.write = 1'b1; ctrl.finish = 1'b1;
          ctrl.wsrc   = (opR == S_PSHA) ? W_ACC : W_ST;
        end
        S_PLLA, S_PLLP: begin
          ctrl.access = 1'b1; ctrl.spOff = 3'd1; ctrl.finish = 1'b1;
        end
        S_RST: begin
          ctrl.access = 1'b1; ctrl.useVec = 1'b1;
          if (stepR == 0) ctrl.capLo = 1'b1;
          else begin ctrl.vecHi = 1'b1; ctrl.finish = 1'b1; end
        end
        default: ctrl.finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      opR   <= S_NONE;
      stepR <= '0;
    end else if (ctrl.load) begin
      busyR <= 1'b1;
      opR   <= decodeOp(opKind, nmiPend, irqPend, iMask);
      stepR <= '0;
    end else if (busyR) begin
      if (ctrl.finish) busyR <= 1'b0;
      else stepR <= stepR + 1'b1;
    end
  end

  assign busy  = busyR;
  assign opCur = opR;

endmodule

// File: rtl/stk_seq_dp.sv
module stk_seq_dp
  import stk_seq_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter int          CYC_W   = 4,
  parameter logic [7:0]  PAGE    = 8'h01,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE,
  parameter logic [7:0]  PWR_SP  = 8'hFD,
  parameter logic [7:0]  PWR_ST  = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  seqOp_e            opCur,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [ADDR_W-1:0] targetIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              done,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] accOut,
  output logic [CYC_W-1:0]  cyclesOut
);

  localparam logic [DATA_W-1:0] BRK_BIT = 8'h10;
  localparam logic [DATA_W-1:0] DIS_BIT = 8'h04;

  logic [ADDR_W-1:0] pcR, tgtR, retPc, word;
  logic [DATA_W-1:0] spR, stR, accR, loR, popStR, stkLow;
  logic [ADDR_W-1:0] vecBase, vecAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcR <= '0; tgtR <= '0; spR <= '0; stR <= '0; accR <= '0;
      loR <= '0; popStR <= '0;
    end else begin
      if (ctrl.load) begin
        pcR <= pcIn; tgtR <= targetIn; spR <= spIn; stR <= statusIn; accR <= accIn;
      end
      if (ctrl.capLo) loR    <= memRdata;
      if (ctrl.capSt) popStR <= memRdata;
    end
  end

  assign stkLow = spR + {{(DATA_W-3){ctrl.spOff[2]}}, ctrl.spOff};
  always_comb begin
    case (opCur)
      S_NMI:   vecBase = NMI_VEC;
      S_RST:   vecBase = RST_VEC;
      default: vecBase = IRQ_VEC;
    endcase
  end
  assign vecAddr = vecBase + {{(ADDR_W-1){1'b0}}, ctrl.vecHi};
  assign memAddr = ctrl.useVec ? vecAddr : {PAGE, stkLow};
  assign memEn   = ctrl.access;
  assign memWe   = ctrl.access && ctrl.write;
  assign retPc   = pcR - 1'b1;

  always_comb begin
    case (ctrl.wsrc)
      W_PCHI:  memWdata = pcR[15:8];
      W_PCLO:  memWdata = pcR[7:0];
      W_RETHI: memWdata = retPc[15:8];
      W_RETLO: memWdata = retPc[7:0];
      W_ST:    memWdata = stR;
      W_STBRK: memWdata = stR | BRK_BIT;
      default: memWdata = accR;
    endcase
  end

  assign word = {memRdata, loR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; pcOut <= '0; spOut <= PWR_SP; statusOut <= PWR_ST;
      accOut <= '0; cyclesOut <= '0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.finish) begin
        pcOut <= pcR; spOut <= spR; statusOut <= stR; accOut <= accR;
        case (opCur)
          S_CALL: begin pcOut <= tgtR; spOut <= spR - 8'd2; cyclesOut <= 4'd6; end
          S_RET:  begin pcOut <= word + 1'b1; spOut <= spR + 8'd2; cyclesOut <= 4'd6; end
          S_BRK: begin
            pcOut <= word; spOut <= spR - 8'd3; cyclesOut <= 4'd7;
            statusOut <= stR | BRK_BIT | DIS_BIT;
          end
          S_NMI, S_IRQ, S_RST: begin
            pcOut <= word; spOut <= spR - 8'd3; cyclesOut <= 4'd7;
            statusOut <= stR | DIS_BIT;
          end
          S_RTI: begin
            pcOut <= word; spOut <= spR + 8'd3; statusOut <= popStR; cyclesOut <= 4'd6;
          end
          S_PSHA, S_PSHP: begin spOut <= spR - 8'd1; cyclesOut <= 4'd3; end
          S_PLLA: begin
            spOut <= spR + 8'd1; accOut <= memRdata; cyclesOut <= 4'd4;
            statusOut <= {memRdata[7], stR[6:2], (memRdata == '0), stR[0]};
          end
          S_PLLP: begin spOut <= spR + 8'd1; statusOut <= memRdata; cyclesOut <= 4'd4; end
          default: cyclesOut <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter logic [7:0]  PAGE    = 8'h01,
  parameter logic [15:0] NMI_VEC = 16'hFFFA,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  parameter logic [15:0] IRQ_VEC = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [3:0]  opKind,
  input  logic [15:0] pcIn,
  input  logic [7:0]  spIn,
  input  logic [7:0]  statusIn,
  input  logic [7:0]  accIn,
  input  logic [15:0] targetIn,
  input  logic        nmiPend,
  input  logic        irqPend,
  input  logic [7:0]  memRdata,
  output logic        busy,
  output logic        done,
  output logic        memEn,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic [15:0] pcOut,
  output logic [7:0]  spOut,
  output logic [7:0]  statusOut,
  output logic [7:0]  accOut,
  output logic [3:0]  cyclesOut
);

  ctrl_t  ctrl;
  seqOp_e opCur;

  stk_seq_ctrl #(.STEP_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opKind(opKind),
    .nmiPend(nmiPend), .irqPend(irqPend), .iMask(statusIn[2]),
    .ctrl(ctrl), .opCur(opCur), .busy(busy)
  );

  stk_seq_dp #(
    .PAGE(PAGE), .NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opCur(opCur),
    .pcIn(pcIn), .spIn(spIn), .statusIn(statusIn), .accIn(accIn),
    .targetIn(targetIn), .memRdata(memRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .done(done), .pcOut(pcOut), .spOut(spOut), .statusOut(statusOut),
    .accOut(accOut), .cyclesOut(cyclesOut)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter logic [7:0] PAGE = 8'h01
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        memEn,
  input logic        memWe,
  input logic [15:0] memAddr,
  input logic [7:0]  spOut,
  input logic [7:0]  statusOut,
  input logic [3:0]  cyclesOut
);

  // R1: every write goes to the stack page
  assert_page_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (memAddr[15:8] == PAGE));

  // R12: no memory traffic while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn);

  // R12: done is a single-cycle pulse that follows a busy cycle
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R12: results only move on the done pulse
  assert_sp_at_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spOut) |-> done);

  // R5: any seven-cycle entry leaves interrupts disabled
  assert_entry_masks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && cyclesOut == 4'd7) |-> statusOut[2]);

endmodule

bind stk_seq stk_seq_chk #(.PAGE(PAGE)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memEn(memEn),
  .memWe(memWe), .memAddr(memAddr), .spOut(spOut), .statusOut(statusOut),
  .cyclesOut(cyclesOut)
);

// File: tb/stk_seq_test.sv
module stk_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [3:0]  opKind = '0;
  logic [15:0] pcIn = '0, targetIn = '0;
  logic [7:0]  spIn = '0, statusIn = '0, accIn = '0;
  logic        nmiPend = 1'b0, irqPend = 1'b0;
  logic [7:0]  memRdata;
  logic        busy, done, memEn, memWe;
  logic [15:0] memAddr, pcOut;
  logic [7:0]  memWdata, spOut, statusOut, accOut;
  logic [3:0]  cyclesOut;

  int errors = 0;
  int checks = 0;

  logic [7:0] stkMem [256];
  logic [7:0] vecMem [8];

  always #2.5 clk = ~clk;

  stk_seq uut (.*);

  always_comb begin
    if (memAddr[15:8] == 8'h01)         memRdata = stkMem[memAddr[7:0]];
    else if (memAddr[15:3] == 13'h1FFF) memRdata = vecMem[memAddr[2:0]];
    else                                memRdata = 8'h00;
  end

  always @(posedge clk) if (memEn && memWe && memAddr[15:8] == 8'h01) stkMem[memAddr[7:0]] <= memWdata;

  // expected access list
  logic [15:0] eA[$];
  logic        eW[$];
  logic [7:0]  eD[$];
  logic [7:0]  mSp;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic pushB(input logic [7:0] d);
    eA.push_back({8'h01, mSp}); eW.push_back(1'b1); eD.push_back(d);
    stkMem_shadow(mSp, d);
    mSp = mSp - 8'd1;
  endtask

  // shadow of pending writes so pulls inside one op see pushed data (none do, kept for order)
  logic [7:0] shadow [256];
  task automatic stkMem_shadow(input logic [7:0] a, input logic [7:0] d);
    shadow[a] = d;
  endtask

  function automatic logic [7:0] pullB();
    mSp = mSp + 8'd1;
    eA.push_back({8'h01, mSp}); eW.push_back(1'b0); eD.push_back(8'h00);
    return stkMem[mSp];
  endfunction

  function automatic logic [15:0] vecRd(input logic [15:0] a);
    eA.push_back(a); eW.push_back(1'b0); eD.push_back(8'h00);
    eA.push_back(a + 16'd1); eW.push_back(1'b0); eD.push_back(8'h00);
    return {vecMem[a[2:0] + 3'd1], vecMem[a[2:0]]};
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [15:0] pc, input logic [7:0] sp,
                       input logic [7:0] st, input logic [7:0] acc, input logic [15:0] tgt,
                       input bit nmi, input bit irq, input bit poke, input string req);
    logic [15:0] xPc; logic [7:0] xSt, xAcc, lo, hi, b; logic [3:0] xCyc;
    int k;
    eA.delete(); eW.delete(); eD.delete();
    mSp = sp; xPc = pc; xSt = st; xAcc = acc; xCyc = 4'd0;
    case (op)
      4'd0: begin pushB(8'((pc - 16'd1) >> 8)); pushB(8'(pc - 16'd1)); xPc = tgt; xCyc = 6; end
      4'd1: begin lo = pullB(); hi = pullB(); xPc = {hi, lo} + 16'd1; xCyc = 6; end
      4'd2: begin
        pushB(pc[15:8]); pushB(pc[7:0]); pushB(st | 8'h10);
        xPc = vecRd(16'hFFFE); xSt = st | 8'h14; xCyc = 7;
      end
      4'd3: begin b = pullB(); lo = pullB(); hi = pullB(); xPc = {hi, lo}; xSt = b; xCyc = 6; end
      4'd4: begin pushB(acc); xCyc = 3; end
      4'd6: begin pushB(st); xCyc = 3; end
      4'd5: begin xAcc = pullB(); xSt = {xAcc[7], st[6:2], xAcc == 8'h00, st[0]}; xCyc = 4; end
      4'd7: begin xSt = pullB(); xCyc = 4; end
      4'd8: begin
        if (nmi || (irq && !st[2])) begin
          pushB(pc[15:8]); pushB(pc[7:0]); pushB(st);
          xPc = vecRd(nmi ? 16'hFFFA : 16'hFFFE); xSt = st | 8'h04; xCyc = 7;
        end
      end
      4'd9: begin xPc = vecRd(16'hFFFC); mSp = sp - 8'd3; xSt = st | 8'h04; xCyc = 7; end
      default: ;
    endcase
    @(negedge clk);
    opKind = op; pcIn = pc; spIn = sp; statusIn = st; accIn = acc; targetIn = tgt;
    nmiPend = nmi; irqPend = irq; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    k = 0;
    while (!done && k < 20) begin
      if (poke && k == 1) begin startValid = 1'b1; opKind = 4'd5; end
      if (poke && k == 2) startValid = 1'b0;
      check(busy == 1'b1, {req, " R12 busy during sequence"}, busy, 1);
      if (memEn) begin
        if (eA.size() == 0) check(1'b0, {req, " R1 unexpected access"}, memAddr, 0);
        else begin
          logic [15:0] a; logic w; logic [7:0] d;
          a = eA.pop_front(); w = eW.pop_front(); d = eD.pop_front();
          check(memAddr == a, {req, " R1 access address"}, memAddr, a);
          check(memWe == w, {req, " R1 access direction"}, memWe, w);
          if (w) check(memWdata == d, {req, " write data"}, memWdata, d);
        end
      end
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, {req, " R12 done seen"}, done, 1);
    check(eA.size() == 0, {req, " R12 all accesses made"}, eA.size(), 0);
    check(busy == 1'b0, {req, " R12 idle at done"}, busy, 0);
    check(pcOut == xPc, {req, " pc"}, pcOut, xPc);
    check(spOut == mSp, {req, " R1 sp"}, spOut, mSp);
    check(statusOut == xSt, {req, " status"}, statusOut, xSt);
    check(accOut == xAcc, {req, " R8 acc"}, accOut, xAcc);
    check(cyclesOut == xCyc, {req, " R11 cycles"}, cyclesOut, xCyc);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {req, " R12 done one cycle, poke ignored"}, {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R12 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (stkMem[i]) stkMem[i] = 8'h00;
    vecMem[0] = 8'h11; vecMem[1] = 8'h22;
    vecMem[2] = 8'h00; vecMem[3] = 8'h90;  // 0xFFFA -> 0x9000
    vecMem[4] = 8'h00; vecMem[5] = 8'h80;  // 0xFFFC -> 0x8000
    vecMem[6] = 8'h00; vecMem[7] = 8'hA0;  // 0xFFFE -> 0xA000
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pcOut == 16'h0000, "R10 reset pc", pcOut, 16'h0000);
    check(spOut == 8'hFD, "R10 reset sp", spOut, 8'hFD);
    check(statusOut == 8'h34, "R10 reset status", statusOut, 8'h34);
    check(accOut == 8'h00 && busy == 1'b0 && memEn == 1'b0, "R10 R12 reset idle", {accOut, busy, memEn}, 0);

    runOp(4'd0, 16'h1234, 8'hFD, 8'h20, 8'h00, 16'h4000, 0, 0, 0, "R2 call");
    runOp(4'd1, 16'h4000, 8'hFB, 8'h20, 8'h00, 16'h0000, 0, 0, 0, "R3 return");
    runOp(4'd2, 16'h2002, 8'hFD, 8'h20, 8'h00, 16'h0000, 0, 0, 1, "R4 break");
    runOp(4'd3, 16'hA000, 8'hFA, 8'h34, 8'h00, 16'h0000, 0, 0, 0, "R7 rti");
    runOp(4'd8, 16'h3000, 8'hFD, 8'h00, 8'h00, 16'h0000, 1, 1, 0, "R6 R5 nmi priority");
    runOp(4'd8, 16'h3100, 8'hF0, 8'h00, 8'h00, 16'h0000, 0, 1, 0, "R5 irq");
    runOp(4'd8, 16'h3200, 8'hF0, 8'h04, 8'h00, 16'h0000, 0, 1, 0, "R6 irq masked");
    runOp(4'd8, 16'h3300, 8'hF0, 8'h00, 8'h00, 16'h0000, 0, 0, 0, "R6 none pending");
    runOp(4'd4, 16'h0000, 8'h00, 8'h02, 8'h80, 16'h0000, 0, 0, 0, "R1 R8 push wrap");
    runOp(4'd5, 16'h0000, 8'hFF, 8'h02, 8'h00, 16'h0000, 0, 0, 0, "R1 R8 pull wrap");
    runOp(4'd4, 16'h0000, 8'h40, 8'h80, 8'h00, 16'h0000, 0, 0, 0, "R8 push zero");
    runOp(4'd5, 16'h0000, 8'h3F, 8'h80, 8'h55, 16'h0000, 0, 0, 0, "R8 pull zero");
    runOp(4'd6, 16'h0000, 8'h50, 8'hC3, 8'h00, 16'h0000, 0, 0, 0, "R8 push status");
    runOp(4'd7, 16'h0000, 8'h4F, 8'h00, 8'h00, 16'h0000, 0, 0, 0, "R8 pull status");
    runOp(4'd9, 16'h5555, 8'h00, 8'h30, 8'h00, 16'h0000, 0, 0, 0, "R9 reset entry");
    runOp(4'd0, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0123, 0, 0, 0, "R1 R2 call wrap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule